// File: doc/BRIEF.md
# Serially Programmed Glitch-Free Clock Stop

This block gates a bank of source clocks under control of a two-wire serial port. The port has a serial clock that never stops and a data line. While idle the data line rests high. A low sample marks the start of a frame, and the twelve samples after it form an enable word. The whole word is moved into the enable register in one step once the last bit has arrived. Two further source clocks pass straight to their outputs and cannot be stopped.

Each gated output has its own cell. The cell brings its enable bit into the domain of its source clock with a two-flop synchroniser. It then holds the bit in a latch that is transparent only while the source clock is low, and ANDs the held bit with the clock. As a result an output starts or stops only during a low phase. Every pulse it emits is a full-width pulse of its source, and a stopped output rests at 0.

The receiver has two states. In `RX_IDLE` a high sample keeps the state (transition *idle-hold*), and a low sample moves to `RX_SHIFT` and clears the bit counter (transition *start-detect*). In `RX_SHIFT` each sample is stored at the counter position while the counter advances (transition *shift-bit*). The sample taken at count 11 commits the word to the enable register and returns the receiver to `RX_IDLE` (transition *commit-return*). No stop bit is checked.

Top module: `clkstop_serial_gate`

## Requirements
- R1: `ser_din` is sampled on each rising edge of `ser_clk`, and each frame bit occupies exactly one `ser_clk` period.
- R2: While the receiver is idle, a sample of 1 has no effect. A sample of 0 is a start bit, and the next 12 samples are taken as data bits.
- R3: Data bit k (k = 0 for the first bit after the start bit, up to k = 11) controls `clk_gated[k]`. The outputs are ordered bank A 0..3, bank B 0..3, bank C 1..3, then sync.
- R4: An enable value of 1 lets the output follow its source clock. A value of 0 stops the output and holds it at 0.
- R5: The enable word in force does not change while a frame is being received. The new word takes effect as a whole, at the sample of the twelfth data bit.
- R6: A gated output changes between running and stopped only while its source clock is low. Every high pulse on an output lasts exactly one high phase of its source clock.
- R7: `clk_fixed` always follows `src_fixed`, whatever enable word is loaded.
- R8: After reset all 12 enable bits are 1, so every output runs.
- R9: After the twelfth data bit the receiver returns to idle without checking for a stop bit. A 0 sampled on the very next edge starts a new frame, so frames can be sent back to back.
- R10: Each gated output reflects a committed enable word within four periods of its own source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ser_clk | input | 1 | Serial clock that never stops |
| ser_din | input | 1 | Serial data line, high while idle |
| src_gated | input | 12 | Source clocks of the gateable outputs |
| src_fixed | input | 2 | Source clocks of the outputs that always run |
| clk_gated | output | 12 | Gated clock outputs, one per enable bit |
| clk_fixed | output | 2 | Ungated clock outputs |

## Verification
Two things can happen in the same cycle: the commit of one frame's last data bit, and the sampling of the next frame's start bit on the following edge. At the same time, the commit can land in a gating cell while that cell's source clock is high. The bench provokes both. It sends frames back to back with no idle bit between them. It also drives fourteen source clocks with different half periods, so enable changes reach the cells at every phase of their sources. It judges the results in three ways: by the final enable pattern seen at the outputs, by a check that the old pattern stays in force in the middle of a frame, and by measuring the width of every output pulse against the high phase of its source.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;
endpackage

// File: rtl/csg_frame_rx.sv
`timescale 1ns/1ps
module csg_frame_rx #(
    parameter int unsigned N_BITS = 12
) (
    input  logic              ser_clk,
    input  logic              rst_n,
    input  logic              ser_din,
    output logic [N_BITS-1:0] en_word
);
    import csg_pkg::*;

    localparam int unsigned CW = (N_BITS > 1) ? $clog2(N_BITS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(N_BITS - 1);

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [N_BITS-1:0] hold_q;
    logic [N_BITS-1:0] en_q;
    logic              last_bit;

    assign last_bit = (cnt_q == LAST_IDX);
    assign en_word  = en_q;

    // state register
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state: idle-hold, start-detect, shift-bit, commit-return
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!ser_din) state_d = RX_SHIFT;
            RX_SHIFT: if (last_bit) state_d = RX_IDLE;
        endcase
    end

    // datapath outputs
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
            en_q   <= '1;
        end else begin
            unique case (state_q)
                RX_IDLE: cnt_q <= '0;
                RX_SHIFT: begin
                    hold_q[cnt_q] <= ser_din;
                    cnt_q         <= cnt_q + 1'b1;
                    if (last_bit) begin
                        en_q <= {ser_din, hold_q[N_BITS-2:0]};
                    end
                end
            endcase
        end
    end

    AST_START_OPENS: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state_q == RX_IDLE && !ser_din) |=> (state_q == RX_SHIFT && cnt_q == '0)); // R2
    AST_HOLD_MID_FRAME: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state_q == RX_SHIFT && !last_bit) |=> $stable(en_word)); // R5
    AST_FRAME_END_IDLE: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state_q == RX_SHIFT && last_bit) |=> (state_q == RX_IDLE)); // R9
endmodule

// File: rtl/csg_gate_cell.sv
`timescale 1ns/1ps
module csg_gate_cell #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic en_async,
    output logic clk_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_lat;

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
    end

    // transparent only in the low phase of the source clock
    always_latch begin
        if (!rst_n)        en_lat = 1'b1;
        else if (!clk_src) en_lat = sync_q[SYNC_STAGES-1];
    end

    assign clk_out = clk_src & en_lat;

    always_comb begin
        if (rst_n && !en_lat) begin
            AST_STOP_IS_LOW: assert (!clk_out); // R4
        end
    end

    AST_GATE_FOLLOWS: assert property (@(negedge clk_src) disable iff (!rst_n)
        en_lat |-> clk_out); // R4
endmodule

// File: rtl/clkstop_serial_gate.sv
`timescale 1ns/1ps
module clkstop_serial_gate #(
    parameter int unsigned N_GATED     = 12,
    parameter int unsigned N_FIXED     = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_din,
    input  logic [N_GATED-1:0] src_gated,
    input  logic [N_FIXED-1:0] src_fixed,
    output logic [N_GATED-1:0] clk_gated,
    output logic [N_FIXED-1:0] clk_fixed
);
    logic [N_GATED-1:0] en_word;

    csg_frame_rx #(.N_BITS(N_GATED)) u_rx (
        .ser_clk (ser_clk),
        .rst_n   (rst_n),
        .ser_din (ser_din),
        .en_word (en_word)
    );

    for (genvar g = 0; g < N_GATED; g++) begin : g_cell
        csg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk_src  (src_gated[g]),
            .rst_n    (rst_n),
            .en_async (en_word[g]),
            .clk_out  (clk_gated[g])
        );
    end

    for (genvar f = 0; f < N_FIXED; f++) begin : g_fixed
        assign clk_fixed[f] = src_fixed[f];
    end
endmodule

// File: tb/clkstop_serial_gate_bench.sv
`timescale 1ns/1ps
module clkstop_serial_gate_bench;
    localparam int NO = 14;

    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_din = 1'b1;
    logic [NO-1:0] src = '0;
    logic [11:0] clk_gated;
    logic [1:0]  clk_fixed;
    logic [NO-1:0] all_o;

    int checks = 0;
    int fails  = 0;
    int win_id = 0;
    int rises [NO];
    bit done = 0;

    assign all_o = {clk_fixed, clk_gated};

    clkstop_serial_gate u_clkstop_serial_gate (
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .src_gated (src[11:0]),
        .src_fixed (src[13:12]),
        .clk_gated (clk_gated),
        .clk_fixed (clk_fixed)
    );

    always #10 ser_clk = ~ser_clk;   // 50 MHz serial clock

    function automatic int hp(input int i);
        return 5 + 2 * i;
    endfunction

    function automatic bit exp_run(input logic [11:0] w, input int i);
        return (i >= 12) ? 1'b1 : w[i];
    endfunction

    // source clocks with distinct half periods
    initial begin
        int tick;
        tick = 0;
        forever begin
            #1;
            tick++;
            for (int i = 0; i < NO; i++) begin
                if (tick % hp(i) == 0) src[i] = ~src[i];
            end
        end
    end

    // monitor: edge counting per window and pulse-width check (R6)
    initial begin
        logic [NO-1:0] prev_o;
        real rise_t [NO];
        int  last_win;
        prev_o = '0;
        last_win = 0;
        for (int i = 0; i < NO; i++) begin
            rises[i] = 0;
            rise_t[i] = 0.0;
        end
        forever begin
            @(all_o or win_id);
            if (win_id != last_win) begin
                last_win = win_id;
                for (int i = 0; i < NO; i++) rises[i] = 0;
            end
            for (int i = 0; i < NO; i++) begin
                if (!prev_o[i] && all_o[i]) begin
                    rise_t[i] = $realtime;
                    rises[i]++;
                end else if (prev_o[i] && !all_o[i] && rst_n) begin
                    real w;
                    w = $realtime - rise_t[i];
                    checks++;
                    if (w < hp(i) - 0.001 || w > hp(i) + 0.001) begin
                        fails++;
                        $display("FAIL R6 output %0d pulse width actual %0.3f expected %0d", i, w, hp(i));
                    end
                end
            end
            prev_o = all_o;
        end
    end

    task automatic check_counts(input logic [11:0] w, input string tag);
        for (int i = 0; i < NO; i++) begin
            bit run, ok;
            run = exp_run(w, i);
            ok  = run ? (rises[i] > 0) : (rises[i] == 0 && all_o[i] == 1'b0);
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL %s output %0d rises actual %0d level %b expected running=%0d",
                         tag, i, rises[i], all_o[i], run);
            end
        end
    endtask

    task automatic settle_check(input logic [11:0] w, input string tag);
        #600;
        win_id++;
        #400;
        check_counts(w, tag);
    endtask

    // start bit, 12 data bits first-to-last; chain leaves no idle bit after
    task automatic send_frame(input logic [11:0] w, input logic [11:0] old_w,
                              input bit mid, input bit chain);
        @(negedge ser_clk) ser_din = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge ser_clk) ser_din = w[i];
            if (mid && i == 1) win_id++;
            if (mid && i == 10) check_counts(old_w, "R5");
        end
        if (!chain) begin
            @(negedge ser_clk) ser_din = 1'b1;
        end
    endtask

    initial begin
        logic [11:0] cur, nw;
        #105;
        rst_n = 1'b1;
        // R8: reset state, all running (idle-high line has no effect, R2)
        settle_check(12'hFFF, "R8");
        // R4 R7: all gated stopped, fixed still running
        send_frame(12'h000, 12'hFFF, 1'b1, 1'b0);
        settle_check(12'h000, "R4");
        // R3: first data bit maps to output 0
        send_frame(12'h001, 12'h000, 1'b1, 1'b0);
        settle_check(12'h001, "R3");
        // R3: last data bit maps to output 11
        send_frame(12'h800, 12'h001, 1'b1, 1'b0);
        settle_check(12'h800, "R3");
        // R9 R1: back-to-back frames, second one wins
        send_frame(12'h5A5, 12'h800, 1'b0, 1'b1);
        send_frame(12'hA5A, 12'h800, 1'b0, 1'b0);
        settle_check(12'hA5A, "R9");
        // R10 R7 R2: random words checked against the function model
        cur = 12'hA5A;
        void'($urandom(32'd2024));
        for (int k = 0; k < 10; k++) begin
            nw = 12'($urandom());
            send_frame(nw, cur, 1'b1, 1'b0);
            settle_check(nw, "R10");
            cur = nw;
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule